// File: doc/BRIEF.md
# I2C Bit-Rate Tick Generator

This block derives the bit timing of an I2C master from a fast reference clock. Software writes one 7-bit rate word that holds two factors: a 4-bit linear factor M and a 3-bit exponent N. A power-of-two prescaler divides the reference clock by 2^(N+1). A linear stage then divides that by M+1 and produces a one-cycle sample tick. Ten ticks make one SCL period. A phase counter numbers the ticks from 0 to 9: phases 0 to 4 are the low half of SCL and phases 5 to 9 are the high half. The byte engine uses the tick, the phase and the half-period flag to place its SCL and SDA edges. The resulting SCL rate is f_ref / (10·(M+1)·2^(N+1)). All 128 factor combinations are legal.

A small controller has two states. HALT holds the divider chain cleared. RUN lets it count. The transitions are as follows. HALT→RUN happens on the first clock edge at which the enable is sampled high. RUN→HALT happens on the first edge at which it is sampled low. A RUN→RUN restart happens on every rate write: the write clears the prescaler, the linear stage and the phase, so the new rate starts from a clean phase. The rate word can also be written in HALT. It is stored and takes effect once the block is enabled.

Top module: `i2c_bitrate_gen`

## Requirements
- R1: After reset, `tick` is 0, `phase` is 0 and `scl_high` is 0. The stored rate word is 0 (M=0, N=0), so an enable with no prior write gives a tick period of 2 cycles.
- R2: A cycle with `rate_wr` high loads `rate_wdata`. Bits 6:3 are M and bits 2:0 are N. The new value sets the tick period from the next cycle on.
- R3: While running, `tick` is a single-cycle pulse. It repeats every D = (M+1)·2^(N+1) reference cycles.
- R4: If `rate_wr` is sampled at a clock edge while enabled, the first tick is high in the D-th cycle after that edge.
- R5: Each tick advances `phase` by one, wrapping from 9 to 0. During the i-th tick after a restart, `phase` reads i mod 10. `scl_high` is 1 exactly when `phase` is 5 to 9.
- R6: While `enable` is low, `tick` stays 0 and `phase` stays 0.
- R7: A rate write while running clears the phase. `phase` reads 0 in the cycle after the write edge, whatever its value before.
- R8: The extreme factors work. M=0, N=0 gives D=2, and M=15, N=7 gives D=4096.
- R9: A rate written while disabled produces no tick. Once `enable` is sampled high at an edge, the first tick is high in the D-th cycle after that edge, with D taken from the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the divider chain when high |
| rate_wr | input | 1 | Write strobe for the rate word |
| rate_wdata | input | 7 | Rate word: M in bits 6:3, N in bits 2:0 |
| tick | output | 1 | Sample strobe at ten times the SCL rate |
| phase | output | 4 | Tick index within the SCL period, 0 to 9 |
| scl_high | output | 1 | High for phases 5 to 9 |

## Verification
The assertions check several cycle-level rules on every cycle:
- both counters stay inside the limits set by the current factors;
- a tick is never followed by another tick;
- each tick steps the phase by exactly one, modulo ten;
- a disabled block emits nothing;
- a write leaves the phase at zero.

The absolute timing needs the bench's scenarios. These cover the exact delay from a write or an enable to the first tick, the tick period for chosen M and N including both extremes, the ordering of the SCL halves, and the stored-while-disabled behaviour.

// File: rtl/i2c_brg_pkg.sv
package i2c_brg_pkg;
    localparam int M_W     = 4;   // linear factor width
    localparam int N_W     = 3;   // exponent width
    localparam int PHASES  = 10;  // ticks per SCL period
    localparam int HALF    = 5;   // ticks in the low half

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } brg_state_e;
endpackage

// File: rtl/i2c_brg_prescaler.sv
module i2c_brg_prescaler #(
    parameter int N_W = i2c_brg_pkg::N_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear_i,
    input  logic [N_W-1:0] n_i,
    output logic           pre_tick_o
);
    localparam int PC_W = 2 ** N_W;

    logic [PC_W-1:0] cnt_q;
    logic [PC_W:0]   span;
    logic [PC_W-1:0] limit;
    logic [N_W:0]    shamt;

    always_comb begin
        shamt = (N_W+1)'(n_i) + (N_W+1)'(1);
        span  = (PC_W+1)'(1) << shamt;
        limit = PC_W'(span - (PC_W+1)'(1));
    end

    assign pre_tick_o = !clear_i && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)  cnt_q <= '0;
        else if (pre_tick_o)    cnt_q <= '0;
        else                    cnt_q <= cnt_q + PC_W'(1);
    end

    // R3: the prescaler never runs past its power-of-two limit
    p_pc_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);
endmodule

// File: rtl/i2c_brg_linear.sv
module i2c_brg_linear #(
    parameter int M_W = i2c_brg_pkg::M_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear_i,
    input  logic           pre_tick_i,
    input  logic [M_W-1:0] m_i,
    output logic           tick_o
);
    logic [M_W-1:0] cnt_q;

    assign tick_o = pre_tick_i && (cnt_q == m_i);

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) cnt_q <= '0;
        else if (tick_o)       cnt_q <= '0;
        else if (pre_tick_i)   cnt_q <= cnt_q + M_W'(1);
    end

    // R3: the linear stage never exceeds M
    p_mc_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= m_i);
endmodule

// File: rtl/i2c_brg_phase.sv
module i2c_brg_phase #(
    parameter int PHASES = i2c_brg_pkg::PHASES,
    parameter int HALF   = i2c_brg_pkg::HALF,
    localparam int PH_W  = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            tick_i,
    output logic [PH_W-1:0] phase_o,
    output logic            high_o
);
    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) phase_q <= '0;
        else if (tick_i)       phase_q <= (phase_q == PH_W'(PHASES-1)) ? '0 : phase_q + PH_W'(1);
    end

    assign phase_o = phase_q;
    assign high_o  = (phase_q >= PH_W'(HALF));

    // R5: phase stays within one SCL period
    p_phase_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q < PH_W'(PHASES));

    // R5: every tick steps the phase by one, modulo the period
    p_phase_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clear_i) |=> (phase_q == (($past(phase_q) == PH_W'(PHASES-1)) ?
                                              PH_W'(0) : $past(phase_q) + PH_W'(1))));
endmodule

// File: rtl/i2c_bitrate_gen.sv
module i2c_bitrate_gen
    import i2c_brg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       rate_wr,
    input  logic [6:0] rate_wdata,
    output logic       tick,
    output logic [3:0] phase,
    output logic       scl_high
);
    localparam int RW_W = M_W + N_W;

    brg_state_e     state_q, state_d;
    logic [RW_W-1:0] rate_q;
    logic [M_W-1:0]  m_fac;
    logic [N_W-1:0]  n_fac;
    logic            run_c, clear_c, pre_tick;

    // rate word
    always_ff @(posedge clk) begin
        if (!rst_n)       rate_q <= '0;
        else if (rate_wr) rate_q <= rate_wdata;
    end
    assign m_fac = rate_q[RW_W-1:N_W];
    assign n_fac = rate_q[N_W-1:0];

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (enable)  state_d = ST_RUN;
            ST_RUN:  if (!enable) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // control outputs of the state machine
    always_comb begin
        run_c   = 1'b0;
        clear_c = 1'b1;
        unique case (state_q)
            ST_HALT: begin
                run_c   = 1'b0;
                clear_c = 1'b1;
            end
            ST_RUN: begin
                run_c   = enable;
                clear_c = rate_wr || !enable;
            end
            default: ;
        endcase
    end

    i2c_brg_prescaler #(.N_W(N_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_c),
        .n_i        (n_fac),
        .pre_tick_o (pre_tick)
    );

    logic lin_tick;
    i2c_brg_linear #(.M_W(M_W)) u_lin (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_c),
        .pre_tick_i (pre_tick && run_c),
        .m_i        (m_fac),
        .tick_o     (lin_tick)
    );

    assign tick = lin_tick && run_c;

    i2c_brg_phase #(.PHASES(PHASES), .HALF(HALF)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_c),
        .tick_i  (tick),
        .phase_o (phase),
        .high_o  (scl_high)
    );

    // R6: nothing is emitted while disabled
    p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !tick);

    // R3: a tick lasts exactly one cycle
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R7: a rate write restarts the SCL phase
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rate_wr |=> (phase == 4'd0));
endmodule

// File: tb/tb_i2c_bitrate_gen.sv
module tb_i2c_bitrate_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       rate_wr = 1'b0;
    logic [6:0] rate_wdata = '0;
    logic       tick;
    logic [3:0] phase;
    logic       scl_high;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;   // 250 MHz

    i2c_bitrate_gen dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rate_wr(rate_wr),
        .rate_wdata(rate_wdata), .tick(tick), .phase(phase), .scl_high(scl_high)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count cycles until the tick; the cycle right after the edge is 1.
    task automatic wait_tick(output int cnt);
        cnt = 1;
        while (!tick && cnt < 10000) begin
            @(negedge clk);
            cnt++;
        end
    endtask

    // Drive a write for one edge; returns at the negedge of cycle 1.
    task automatic write_rate(input int m, input int n);
        @(negedge clk);
        rate_wdata = 7'((m << 3) | n);
        rate_wr    = 1'b1;
        @(negedge clk);
        rate_wr    = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 tick", int'(tick), 0);
        chk("R1 phase", int'(phase), 0);
        chk("R1 scl_high", int'(scl_high), 0);
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        begin
            int c;
            wait_tick(c);
            chk("R1 default first tick", c, 2);
        end
    endtask

    task automatic t_rate(input int m, input int n, input string req);
        int d, c;
        d = (m + 1) * (1 << (n + 1));
        write_rate(m, n);
        chk({req, " R7 phase after write"}, int'(phase), 0);
        wait_tick(c);
        chk({req, " R4 first tick"}, c, d);
        @(negedge clk);
        wait_tick(c);
        chk({req, " R3 R2 period"}, c, d);
    endtask

    task automatic t_phase;
        int c;
        write_rate(0, 0);
        for (int i = 0; i < 23; i++) begin
            wait_tick(c);
            chk("R5 phase at tick", int'(phase), i % 10);
            chk("R5 scl_high at tick", int'(scl_high), ((i % 10) >= 5) ? 1 : 0);
            @(negedge clk);
        end
    endtask

    task automatic t_restart;
        int c;
        write_rate(1, 0);   // D = 4
        for (int i = 0; i < 3; i++) begin
            wait_tick(c);
            @(negedge clk);
        end
        chk("R7 phase before restart", int'(phase), 3);
        write_rate(2, 1);   // D = 12
        chk("R7 phase cleared", int'(phase), 0);
        wait_tick(c);
        chk("R7 first tick after restart", c, 12);
    endtask

    task automatic t_disable;
        int seen, c;
        @(negedge clk);
        enable = 1'b0;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tick) seen++;
        end
        chk("R6 no tick disabled", seen, 0);
        chk("R6 phase disabled", int'(phase), 0);
        write_rate(4, 0);   // D = 10, stored while off
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (tick) seen++;
        end
        chk("R9 no tick after write while off", seen, 0);
        enable = 1'b1;
        @(negedge clk);
        wait_tick(c);
        chk("R9 first tick after enable", c, 10);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_rate(3, 1, "R2");
        t_rate(9, 2, "R3");
        t_rate(0, 0, "R8 min");
        t_rate(15, 7, "R8 max");
        t_rate(6, 4, "R4");
        t_phase;
        t_restart;
        t_disable;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule